// File: doc/BRIEF.md
# Count-Pulse Interrupt Counter Unit

This unit services a bank of count-pulse interrupt levels. Each level owns a counter in memory, plus an operand size (byte, halfword or word) and a signed step. When a pulse arrives on an armed level, that level waits for service. When the processor grants a service slot, the lowest-numbered waiting level becomes active. The unit then performs one read-modify-write of that level's counter and puts the level back into the armed state. No other program state is involved.

The counter field sits in the low bits of the addressed word. The step is added at the selected size and the sum wraps. Bits above the field are written back unchanged. Overflow is discarded silently. If the modified field ends up zero, the unit emits a one-cycle counter-at-zero request for that level and latches it into a pending flag, which stays set until it is acknowledged.

One designated level can address memory through the translated space while translation is enabled. The unit only raises a select line for this; the translation itself happens elsewhere. Every other level always uses physical addresses. The write path carries no protection check and produces no trap.

Top module: `cnt_pulse_unit`

## Requirements
- R1: After reset every level is disarmed, no memory read or write is issued, and all counter-at-zero outputs are low.
- R2: While a level's arm enable is high, a disarmed level becomes armed. Driving the enable low returns an armed or waiting level to disarmed, and that level is then never serviced.
- R3: A pulse on an armed level makes it waiting. A pulse on a disarmed level is ignored. A pulse on a level that is already waiting is absorbed, so only one service follows.
- R4: When grant is high in an idle cycle and levels are waiting, exactly one level becomes active, and it is the lowest-indexed waiting level. A grant with no level waiting starts nothing.
- R5: The read strobe is high in the cycle after the accepted grant, and the write strobe is high in the cycle after that. Both carry the active level's configured address. Read data is expected one cycle after the read strobe.
- R6: Size code 0 modifies bits 7:0, code 1 modifies bits 15:0, and code 2 or 3 modifies the full 32-bit word. Each field receives old field plus step, modulo the field size, with the upper bits preserved. A wrap has no other effect.
- R7: When the write completes, the active level returns to armed, and a later pulse starts a new service.
- R8: When the written field is zero, the level's counter-at-zero pulse is high for exactly the one cycle after the write cycle. Its pending flag rises in that same cycle and holds until an acknowledge pulse on that level's bit.
- R9: A pulse on the active level is held. When the current service ends, the level moves straight to waiting instead of armed.
- R10: The mapped-address select is high during a read or write exactly when the active level is the designated mapped level and the map enable input is high. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_en_i | input | NUM_LVL | Per-level arm enable |
| pulse_i | input | NUM_LVL | Per-level count pulse |
| grant_i | input | 1 | Service slot grant from the processor |
| map_en_i | input | 1 | Address translation enabled in the status word |
| cfg_addr_i | input | NUM_LVL*ADDR_W | Counter word address per level |
| cfg_size_i | input | NUM_LVL*2 | Operand size code per level |
| cfg_step_i | input | NUM_LVL*32 | Signed step per level |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after read strobe |
| mem_mapped_o | output | 1 | Use translated address for this access |
| zero_pulse_o | output | NUM_LVL | One-cycle counter-at-zero request |
| zero_pend_o | output | NUM_LVL | Latched counter-at-zero pending flags |
| zero_ack_i | input | NUM_LVL | Clears the pending flag per level |

## Verification
The bench uses the defaults: four levels, an 8-bit word address, and level 3 as the mapped level. Four levels are enough to test lowest-index priority with waiters above and below other active levels. They also let the mapped level run next to plain levels, so the select line can be seen both high and low under the same map enable. Every size code is driven through its wrap boundary, with the upper word bits set to recognisable patterns.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        LV_DISARMED = 2'd0,
        LV_ARMED    = 2'd1,
        LV_WAITING  = 2'd2,
        LV_ACTIVE   = 2'd3
    } lvl_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } op_size_e;

    typedef enum logic [1:0] {
        SV_IDLE  = 2'd0,
        SV_READ  = 2'd1,
        SV_WRITE = 2'd2
    } svc_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              zero;
    } mod_result_t;

    function automatic logic [WORD_W-1:0] field_mask(op_size_e sz);
        case (sz)
            SZ_BYTE: field_mask = WORD_W'(32'h0000_00FF);
            SZ_HALF: field_mask = WORD_W'(32'h0000_FFFF);
            default: field_mask = '1;
        endcase
    endfunction
endpackage

// File: rtl/cpc_modify.sv
module cpc_modify
    import cpc_pkg::*;
(
    input  logic [WORD_W-1:0] old_i,
    input  logic [WORD_W-1:0] step_i,
    input  op_size_e          size_i,
    output mod_result_t       res_o
);
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] sum;
    logic [WORD_W-1:0] field;

    always_comb begin
        mask       = field_mask(size_i);
        sum        = old_i + step_i;
        field      = sum & mask;
        res_o.word = (old_i & ~mask) | field;
        res_o.zero = (field == '0);
    end

    // R6: bits outside the field pass through untouched
    always_comb begin
        if (size_i == SZ_BYTE)
            a_upper_kept_r6: assert ((res_o.word[WORD_W-1:8] == old_i[WORD_W-1:8]) || $isunknown(old_i));
    end
endmodule

// File: rtl/cpc_level.sv
module cpc_level
    import cpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm_en_i,
    input  logic       pulse_i,
    input  logic       start_i,
    input  logic       done_i,
    output lvl_state_e state_o,
    output logic       waiting_o,
    output logic       active_o
);
    lvl_state_e st_q, st_d;
    logic       pend_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            LV_DISARMED: if (arm_en_i) st_d = LV_ARMED;
            LV_ARMED: begin
                if (!arm_en_i)    st_d = LV_DISARMED;
                else if (pulse_i) st_d = LV_WAITING;
            end
            LV_WAITING: begin
                if (!arm_en_i)    st_d = LV_DISARMED;
                else if (start_i) st_d = LV_ACTIVE;
            end
            LV_ACTIVE: if (done_i) st_d = (pend_q || pulse_i) ? LV_WAITING : LV_ARMED;
            default: st_d = LV_DISARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LV_DISARMED;
            pend_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (done_i)
                pend_q <= 1'b0;
            else if (st_q == LV_ACTIVE && pulse_i)
                pend_q <= 1'b1;
        end
    end

    assign state_o   = st_q;
    assign waiting_o = (st_q == LV_WAITING);
    assign active_o  = (st_q == LV_ACTIVE);

    p_pulse_waits_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == LV_ARMED && arm_en_i && pulse_i) |=> (st_q == LV_WAITING));
    p_start_from_wait_r4: assert property (@(posedge clk) disable iff (rst)
        start_i |-> (st_q == LV_WAITING));
    p_rearm_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == LV_ACTIVE && done_i && !pend_q && !pulse_i) |=> (st_q == LV_ARMED));
    p_held_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == LV_ACTIVE && pend_q && done_i) |=> (st_q == LV_WAITING));
endmodule

// File: rtl/cpc_pick.sv
module cpc_pick #(
    parameter int NUM_LVL = 4,
    localparam int IDX_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic [NUM_LVL-1:0] req_i,
    output logic [NUM_LVL-1:0] onehot_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               any_o
);
    logic [NUM_LVL:0] lower_seen;

    assign lower_seen[0] = 1'b0;
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_chain
        assign onehot_o[g]     = req_i[g] && !lower_seen[g];
        assign lower_seen[g+1] = lower_seen[g] || req_i[g];
    end

    always_comb begin
        idx_o = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--)
            if (req_i[i]) idx_o = IDX_W'(i);
    end

    assign any_o = lower_seen[NUM_LVL];

    always_comb begin
        a_pick_onehot_r4: assert ($onehot0(onehot_o) || $isunknown(req_i));
    end
endmodule

// File: rtl/cnt_pulse_unit.sv
module cnt_pulse_unit
    import cpc_pkg::*;
#(
    parameter int NUM_LVL = 4,
    parameter int ADDR_W  = 8,
    parameter int MAP_LVL = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LVL-1:0]          arm_en_i,
    input  logic [NUM_LVL-1:0]          pulse_i,
    input  logic                        grant_i,
    input  logic                        map_en_i,
    input  logic [NUM_LVL*ADDR_W-1:0]   cfg_addr_i,
    input  logic [NUM_LVL*2-1:0]        cfg_size_i,
    input  logic [NUM_LVL*WORD_W-1:0]   cfg_step_i,
    output logic                        mem_rd_o,
    output logic                        mem_wr_o,
    output logic [ADDR_W-1:0]           mem_addr_o,
    output logic [WORD_W-1:0]           mem_wdata_o,
    input  logic [WORD_W-1:0]           mem_rdata_i,
    output logic                        mem_mapped_o,
    output logic [NUM_LVL-1:0]          zero_pulse_o,
    output logic [NUM_LVL-1:0]          zero_pend_o,
    input  logic [NUM_LVL-1:0]          zero_ack_i
);
    localparam int IDX_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;

    logic [ADDR_W-1:0] addr_arr [NUM_LVL];
    op_size_e          size_arr [NUM_LVL];
    logic [WORD_W-1:0] step_arr [NUM_LVL];

    logic [NUM_LVL-1:0] waiting, active, pick_oh, start_vec, done_vec;
    logic [IDX_W-1:0]   pick_idx, sel_q;
    logic               any_wait, start;
    svc_state_e         svc_q;
    mod_result_t        res;
    logic [NUM_LVL-1:0] zpulse_q, zpend_q;

    assign start = (svc_q == SV_IDLE) && grant_i && any_wait;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        lvl_state_e st_unused;
        assign addr_arr[g]  = cfg_addr_i[g*ADDR_W +: ADDR_W];
        assign size_arr[g]  = op_size_e'(cfg_size_i[g*2 +: 2]);
        assign step_arr[g]  = cfg_step_i[g*WORD_W +: WORD_W];
        assign start_vec[g] = start && pick_oh[g];
        assign done_vec[g]  = (svc_q == SV_WRITE) && (sel_q == IDX_W'(g));

        cpc_level u_lvl (
            .clk      (clk),
            .rst      (rst),
            .arm_en_i (arm_en_i[g]),
            .pulse_i  (pulse_i[g]),
            .start_i  (start_vec[g]),
            .done_i   (done_vec[g]),
            .state_o  (st_unused),
            .waiting_o(waiting[g]),
            .active_o (active[g])
        );
    end

    cpc_pick #(.NUM_LVL(NUM_LVL)) u_pick (
        .req_i   (waiting),
        .onehot_o(pick_oh),
        .idx_o   (pick_idx),
        .any_o   (any_wait)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q <= SV_IDLE;
            sel_q <= '0;
        end else begin
            case (svc_q)
                SV_IDLE: if (start) begin
                    svc_q <= SV_READ;
                    sel_q <= pick_idx;
                end
                SV_READ:  svc_q <= SV_WRITE;
                default:  svc_q <= SV_IDLE;
            endcase
        end
    end

    cpc_modify u_mod (
        .old_i (mem_rdata_i),
        .step_i(step_arr[sel_q]),
        .size_i(size_arr[sel_q]),
        .res_o (res)
    );

    assign mem_rd_o     = (svc_q == SV_READ);
    assign mem_wr_o     = (svc_q == SV_WRITE);
    assign mem_addr_o   = addr_arr[sel_q];
    assign mem_wdata_o  = res.word;
    assign mem_mapped_o = (svc_q != SV_IDLE) && map_en_i && (sel_q == IDX_W'(MAP_LVL));

    always_ff @(posedge clk) begin
        if (rst) begin
            zpulse_q <= '0;
            zpend_q  <= '0;
        end else begin
            zpulse_q <= done_vec & {NUM_LVL{res.zero}};
            zpend_q  <= (zpend_q & ~zero_ack_i) | (done_vec & {NUM_LVL{res.zero}});
        end
    end

    assign zero_pulse_o = zpulse_q;
    assign zero_pend_o  = zpend_q;

    p_idle_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> (!mem_rd_o && !mem_wr_o && zero_pend_o == '0));
    p_one_active_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(active));
    p_write_follows_read_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |=> mem_wr_o);
    p_wr_addr_stable_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr_o |-> $stable(mem_addr_o));
    p_zero_single_r8: assert property (@(posedge clk) disable iff (rst)
        (zero_pulse_o != '0) |=> (zero_pulse_o == '0));
    p_zero_latched_r8: assert property (@(posedge clk) disable iff (rst)
        ((zero_pulse_o & ~zero_pend_o) == '0));
    p_map_in_access_r10: assert property (@(posedge clk) disable iff (rst)
        mem_mapped_o |-> (mem_rd_o || mem_wr_o));
endmodule

// File: tb/sim_cnt_pulse_unit.sv
`timescale 1ns/1ps
module sim_cnt_pulse_unit;
    localparam int N  = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  arm_en = '0, pulse = '0, zack = '0;
    logic          grant = 1'b0, map_en = 1'b0;
    logic [N*AW-1:0] cfg_addr;
    logic [N*2-1:0]  cfg_size = '0;
    logic [N*32-1:0] cfg_step = '0;
    logic          mem_rd, mem_wr, mem_mapped;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic [N-1:0]  zpulse, zpend;

    logic [31:0]   mem [0:255];
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [31:0]   pre_data = '0;

    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    cnt_pulse_unit u0 (
        .clk(clk), .rst(rst), .arm_en_i(arm_en), .pulse_i(pulse), .grant_i(grant),
        .map_en_i(map_en), .cfg_addr_i(cfg_addr), .cfg_size_i(cfg_size),
        .cfg_step_i(cfg_step), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .mem_mapped_o(mem_mapped), .zero_pulse_o(zpulse), .zero_pend_o(zpend),
        .zero_ack_i(zack)
    );

    always @(posedge clk) begin
        if (pre_we) mem[pre_addr] <= pre_data;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    for (genvar g = 0; g < N; g++) begin : g_addr
        assign cfg_addr[g*AW +: AW] = AW'(8'h10 + g);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic preload(input int lvl, input logic [31:0] val, input logic [1:0] sz, input logic [31:0] step);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = AW'(8'h10 + lvl); pre_data = val;
        cfg_size[lvl*2 +: 2] = sz;
        cfg_step[lvl*32 +: 32] = step;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic hit(input logic [N-1:0] v);
        @(negedge clk); pulse = v;
        @(negedge clk); pulse = '0;
    endtask

    task automatic serve(input string req, input int lvl, input logic [31:0] exp_w,
                         input bit exp_zero, input bit exp_map, input bit pulse_mid);
        @(negedge clk); grant = 1'b1;
        @(negedge clk); grant = 1'b0;
        check({req, " read strobe"}, 32'(mem_rd), 32'd1);
        check({req, " address"}, 32'(mem_addr), 32'(8'h10 + lvl));
        check({req, " mapped select"}, 32'(mem_mapped), 32'(exp_map));
        if (pulse_mid) pulse[lvl] = 1'b1;
        @(negedge clk);
        pulse = '0;
        check({req, " write strobe"}, 32'(mem_wr), 32'd1);
        check({req, " write data"}, mem_wdata, exp_w);
        @(negedge clk);
        check({req, " zero pulse"}, 32'(zpulse[lvl]), 32'(exp_zero));
        if (exp_zero) begin
            check({req, " zero pending"}, 32'(zpend[lvl]), 32'd1);
            zack[lvl] = 1'b1;
            @(negedge clk);
            zack = '0;
            check({req, " zero pulse gone"}, 32'(zpulse[lvl]), 32'd0);
            @(negedge clk);
            check({req, " zero pending cleared"}, 32'(zpend[lvl]), 32'd0);
        end
    endtask

    task automatic expect_idle(input string req);
        @(negedge clk); grant = 1'b1;
        @(negedge clk); grant = 1'b0;
        check({req, " no read"}, 32'(mem_rd), 32'd0);
        @(negedge clk);
        check({req, " no write"}, 32'(mem_wr), 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 read idle", 32'(mem_rd), 32'd0);
        check("R1 write idle", 32'(mem_wr), 32'd0);
        check("R1 zero pulse", 32'(zpulse), 32'd0);
        check("R1 zero pending", 32'(zpend), 32'd0);
    endtask

    task automatic t_disarmed();
        preload(1, 32'hAABB_CCFE, 2'd0, 32'd1);
        hit(4'b0010);
        expect_idle("R3 disarmed pulse ignored");
    endtask

    task automatic t_byte();
        @(negedge clk); arm_en = '1;
        @(negedge clk);
        hit(4'b0010);
        serve("R6 byte step", 1, 32'hAABB_CCFF, 1'b0, 1'b0, 1'b0);
        hit(4'b0010);
        serve("R7 rearmed, R6 byte wrap", 1, 32'hAABB_CC00, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_half();
        preload(2, 32'h1234_FFFF, 2'd1, 32'd1);
        hit(4'b0100);
        serve("R6 half wrap R8", 2, 32'h1234_0000, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_word();
        preload(0, 32'h0000_0005, 2'd2, 32'hFFFF_FFFA);
        hit(4'b0001);
        hit(4'b0001);
        serve("R6 word negative step", 0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        expect_idle("R3 repeat pulse absorbed");
    endtask

    task automatic t_priority();
        preload(0, 32'hFFFF_FFFF, 2'd3, 32'd1);
        hit(4'b0100);
        hit(4'b0001);
        serve("R4 lowest first", 0, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
        serve("R4 next waiter", 2, 32'h1234_0001, 1'b0, 1'b0, 1'b0);
        expect_idle("R4 grant with none waiting");
    endtask

    task automatic t_held();
        preload(1, 32'h0000_0010, 2'd0, 32'd1);
        hit(4'b0010);
        serve("R9 first pass", 1, 32'h0000_0011, 1'b0, 1'b0, 1'b1);
        serve("R9 held pulse served", 1, 32'h0000_0012, 1'b0, 1'b0, 1'b0);
        expect_idle("R9 single extra service");
    endtask

    task automatic t_mapped();
        preload(3, 32'h0000_0000, 2'd2, 32'd2);
        @(negedge clk); map_en = 1'b1;
        hit(4'b1000);
        serve("R10 mapped level", 3, 32'h0000_0002, 1'b0, 1'b1, 1'b0);
        hit(4'b0001);
        serve("R10 plain level", 0, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
        @(negedge clk); map_en = 1'b0;
        hit(4'b1000);
        serve("R10 map disabled", 3, 32'h0000_0004, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_disarm();
        hit(4'b0100);
        @(negedge clk); arm_en[2] = 1'b0;
        @(negedge clk);
        expect_idle("R2 disarmed waiter dropped");
        @(negedge clk); arm_en[2] = 1'b1;
        @(negedge clk);
        hit(4'b0100);
        serve("R2 rearmed by enable", 2, 32'h1234_0002, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_disarmed();
        t_byte();
        t_half();
        t_word();
        t_priority();
        t_held();
        t_mapped();
        t_disarm();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule